// File: doc/BRIEF.md
# Hierarchical Fault Summary Aggregator

This block gathers single-cycle fault event pulses from twelve fault groups: protection, under-temperature, over-temperature, under-voltage, over-voltage, comparison, system, power, OTP memory, and three communication tiers. Each event bit latches into a sticky low-level flag, which stays set until software clears it by writing a one to that bit. From the flags the block builds a ten-bit summary word with one bit per summary group, and it drives an active-low fault pin.

Two mask registers sit between the flags and the summary. A mask never stops a flag from latching. It only stops that flag from reaching the summary and the pin. Some summary bits are fed by several independently masked categories. Such a bit is fully suppressed only when every category that feeds it is masked. A small register port gives read and write access to the flags, to the masks and to the summary.

Group slots are indexed 0 PROT, 1 UT, 2 OT, 3 UV, 4 OV, 5 COMP, 6 SYS, 7 PWR, 8 OTP, 9 COMM3, 10 COMM2, 11 COMM1. Each slot has `DW` event bits at `evt_i[g*DW +: DW]`. Only the low bits up to the group's configured width are implemented. The default widths are 2, 4, 4, 6, 6, 3, 5, 4, 6, 4, 3 and 4.

Top module: `fault_summary_agg`

## Requirements
- R1: A pulse on an implemented event bit sets the matching flag at the next clock edge, whatever the masks hold. Event bits above a group's width never set anything.
- R2: Flags are sticky. A write to group address g (0..11) clears exactly the flag bits of that group where `wdata_i` is 1. All other flags stay as they were.
- R3: When an event and a clearing write hit the same flag bit in the same cycle, the flag stays set.
- R4: Summary bits and their masks: bit0 PROT (mask1 bit0), bit3 COMP (mask1 bit5), bit4 SYS (mask1 bit6), bit5 PWR (mask1 bit7), bit8 COMM2 (mask2 bit5), bit9 COMM1 (mask2 bit6). Each summary bit is 1 when any flag of its group is set and its mask bit is 0.
- R5: Summary bit1 is the OR of the UT flags gated by mask1 bit1 and the OT flags gated by mask1 bit2. Summary bit2 is the OR of the UV flags gated by mask1 bit3 and the OV flags gated by mask1 bit4.
- R6: Summary bit6 comes from the OTP flags. Flag bits 0 and 1 (the two CRC flags) are gated by mask2 bit0. All higher OTP bits (data and debug) are gated by mask2 bit1.
- R7: Summary bit7 comes from the COMM3 flags. Bit0 (fault-comm detect) is gated by mask2 bit2, bit1 (tone detect) by mask2 bit3, and bits 2 and 3 (heartbeat fail and heartbeat fast) by mask2 bit4.
- R8: `nfault_o` is 0 exactly when any summary bit is 1. With every mask bit set it stays 1 even while flags are set.
- R9: A mask write changes the summary and the pin in the cycle after the write and leaves every flag unchanged.
- R10: Address 12 holds mask1 (8 bits) and address 13 holds mask2 (7 bits). Both read back zero-extended. Address 14 reads the summary, and writes to it are ignored. Address 15 reads zero. Reads are combinational from `addr_i`.
- R11: After reset all flags and masks are 0, the summary is 0 and `nfault_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 12*DW | Fault event pulses, one DW slot per group |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | DW | Write data (write-one-to-clear for flag groups) |
| rdata_o | output | DW | Read data for `addr_i` |
| summary_o | output | 10 | Masked per-group summary |
| nfault_o | output | 1 | Active-low fault pin |

## Verification
A corrupted flag or mask register shows up at `summary_o` and `nfault_o` one clock after the write or event that exposes it. The bench therefore compares both outputs with a behavioural model on every cycle, so an error is reported in the cycle it first becomes visible. A flag error hidden behind a mask still shows on a read of that group's address. Directed reads after each mask and clear step catch flags that change when they should not, or stay set when they should clear.

// File: rtl/fault_summary_agg.sv
module fault_summary_agg #(
  parameter int DW      = 16,
  parameter int PROT_W  = 2,
  parameter int TEMP_W  = 4,
  parameter int CELL_W  = 6,
  parameter int COMP_W  = 3,
  parameter int SYS_W   = 5,
  parameter int PWR_W   = 4,
  parameter int OTP_W   = 6,
  parameter int COMM2_W = 3,
  parameter int COMM1_W = 4,
  localparam int NGRP   = 12,
  localparam int NSUM   = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NGRP*DW-1:0]   evt_i,
  input  logic                 wr_en_i,
  input  logic [3:0]           addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  output logic [NSUM-1:0]      summary_o,
  output logic                 nfault_o
);

  localparam int G_PROT = 0, G_UT = 1, G_OT = 2, G_UV = 3, G_OV = 4, G_COMP = 5;
  localparam int G_SYS = 6, G_PWR = 7, G_OTP = 8, G_CM3 = 9, G_CM2 = 10, G_CM1 = 11;
  localparam logic [3:0] A_MASK1 = 4'd12, A_MASK2 = 4'd13, A_SUM = 4'd14;

  function automatic int grp_w(int g);
    case (g)
      G_PROT:      return PROT_W;
      G_UT, G_OT:  return TEMP_W;
      G_UV, G_OV:  return CELL_W;
      G_COMP:      return COMP_W;
      G_SYS:       return SYS_W;
      G_PWR:       return PWR_W;
      G_OTP:       return OTP_W;
      G_CM3:       return 4;
      G_CM2:       return COMM2_W;
      default:     return COMM1_W;
    endcase
  endfunction

  function automatic logic [DW-1:0] vld(int g);
    return {DW{1'b1}} >> (DW - grp_w(g));
  endfunction

  function automatic logic [NGRP*DW-1:0] vld_all();
    logic [NGRP*DW-1:0] v;
    for (int g = 0; g < NGRP; g++) v[g*DW +: DW] = vld(g);
    return v;
  endfunction

  localparam logic [NGRP*DW-1:0] VLD_ALL = vld_all();

  logic [NGRP-1:0][DW-1:0] flag_q;
  logic [NGRP-1:0][DW-1:0] clr;
  logic [7:0]              m1_q;
  logic [6:0]              m2_q;

  always_comb begin
    for (int g = 0; g < NGRP; g++)
      clr[g] = (wr_en_i && addr_i == 4'(g)) ? wdata_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else begin
      for (int g = 0; g < NGRP; g++)
        flag_q[g] <= (flag_q[g] & ~clr[g]) | (evt_i[g*DW +: DW] & vld(g));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1_q <= '0;
      m2_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == A_MASK1) m1_q <= wdata_i[7:0];
      if (addr_i == A_MASK2) m2_q <= wdata_i[6:0];
    end
  end

  function automatic logic live(logic [DW-1:0] f, logic m);
    return (|f) && !m;
  endfunction

  assign summary_o[0] = live(flag_q[G_PROT], m1_q[0]);
  assign summary_o[1] = live(flag_q[G_UT], m1_q[1]) | live(flag_q[G_OT], m1_q[2]);
  assign summary_o[2] = live(flag_q[G_UV], m1_q[3]) | live(flag_q[G_OV], m1_q[4]);
  assign summary_o[3] = live(flag_q[G_COMP], m1_q[5]);
  assign summary_o[4] = live(flag_q[G_SYS], m1_q[6]);
  assign summary_o[5] = live(flag_q[G_PWR], m1_q[7]);
  assign summary_o[6] = live(flag_q[G_OTP] & DW'(3), m2_q[0])
                      | live(flag_q[G_OTP] & ~DW'(3), m2_q[1]);
  assign summary_o[7] = live(flag_q[G_CM3] & DW'(1), m2_q[2])
                      | live(flag_q[G_CM3] & DW'(2), m2_q[3])
                      | live(flag_q[G_CM3] & DW'(12), m2_q[4]);
  assign summary_o[8] = live(flag_q[G_CM2], m2_q[5]);
  assign summary_o[9] = live(flag_q[G_CM1], m2_q[6]);

  assign nfault_o = ~|summary_o;

  always_comb begin
    rdata_o = '0;
    if (addr_i < 4'(NGRP)) rdata_o = flag_q[addr_i];
    else if (addr_i == A_MASK1) rdata_o = DW'(m1_q);
    else if (addr_i == A_MASK2) rdata_o = DW'(m2_q);
    else if (addr_i == A_SUM) rdata_o = DW'(summary_o);
  end

endmodule

// File: rtl/fault_summary_agg_chk.sv
module fault_summary_agg_chk #(
  parameter int DW = 16,
  parameter int NGRP = 12,
  parameter logic [NGRP*DW-1:0] VLD = '1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NGRP*DW-1:0] evt_i,
  input logic               wr_en_i,
  input logic [3:0]         addr_i,
  input logic [NGRP*DW-1:0] flags,
  input logic [7:0]         m1,
  input logic [6:0]         m2,
  input logic [9:0]         summary_o,
  input logic               nfault_o
);

  p_event_sets_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(evt_i & VLD)) == $past(evt_i & VLD)));

  p_unimpl_bits_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~VLD) == '0);

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && addr_i < 4'(NGRP)) |=> ((flags & $past(flags)) == $past(flags)));

  p_event_beats_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i < 4'(NGRP) && (evt_i & VLD) != '0)
      |=> ((flags & $past(evt_i & VLD)) == $past(evt_i & VLD)));

  p_no_summary_without_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> (summary_o == '0 && nfault_o));

  p_all_masked_pin_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m1 == 8'hFF && m2 == 7'h7F) |-> (nfault_o && summary_o == '0));

  p_mask_write_keeps_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i >= 4'(NGRP)) |=> (flags == ($past(flags) | $past(evt_i & VLD))));

endmodule

bind fault_summary_agg fault_summary_agg_chk #(.DW(DW), .NGRP(NGRP), .VLD(VLD_ALL)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .flags(flag_q), .m1(m1_q), .m2(m2_q), .summary_o(summary_o), .nfault_o(nfault_o)
);

// File: tb/fault_summary_agg_tb_top.sv
module fault_summary_agg_tb_top;
  localparam int DW = 16;
  localparam int NG = 12;

  logic clk = 0, rst_n = 0;
  logic [NG*DW-1:0] evt = '0;
  logic wr_en = 0;
  logic [3:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic [9:0] summary;
  logic nfault;

  fault_summary_agg dut_i (.clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .summary_o(summary), .nfault_o(nfault));

  always #4 clk = ~clk;

  int total = 0, fails = 0;
  int unsigned rf[NG];
  int unsigned m1 = 0, m2 = 0;
  int widths[NG] = '{2, 4, 4, 6, 6, 3, 5, 4, 6, 4, 3, 4};
  bit live_cmp = 0;

  function automatic int unsigned ref_sum();
    int unsigned s = 0;
    if (rf[0] != 0 && m1[0] == 0) s |= 1;
    if ((rf[1] != 0 && m1[1] == 0) || (rf[2] != 0 && m1[2] == 0)) s |= 2;
    if ((rf[3] != 0 && m1[3] == 0) || (rf[4] != 0 && m1[4] == 0)) s |= 4;
    if (rf[5] != 0 && m1[5] == 0) s |= 8;
    if (rf[6] != 0 && m1[6] == 0) s |= 16;
    if (rf[7] != 0 && m1[7] == 0) s |= 32;
    if (((rf[8] % 4) != 0 && m2[0] == 0) || ((rf[8] / 4) != 0 && m2[1] == 0)) s |= 64;
    if (((rf[9] % 2) != 0 && m2[2] == 0) || (((rf[9] / 2) % 2) != 0 && m2[3] == 0)
        || ((rf[9] / 4) != 0 && m2[4] == 0)) s |= 128;
    if (rf[10] != 0 && m2[5] == 0) s |= 256;
    if (rf[11] != 0 && m2[6] == 0) s |= 512;
    return s;
  endfunction

  function automatic int unsigned ref_read(int a);
    if (a < NG) return rf[a];
    if (a == 12) return m1;
    if (a == 13) return m2;
    if (a == 14) return ref_sum();
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (rf[g]) rf[g] = 0;
      m1 = 0; m2 = 0;
    end else begin
      if (wr_en) begin
        if (addr < NG) rf[addr] = rf[addr] & ~int'(wdata);
        else if (addr == 12) m1 = wdata % 256;
        else if (addr == 13) m2 = wdata % 128;
      end
      for (int g = 0; g < NG; g++)
        rf[g] = rf[g] | (int'(evt[g*DW +: DW]) % (1 << widths[g]));
    end
  end

  task automatic check(string tag, int unsigned act, int unsigned exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (live_cmp) begin
    check("R4 R5 R6 R7 summary", summary, ref_sum());
    check("R8 nfault", nfault, ref_sum() == 0);
  end

  function automatic logic [NG*DW-1:0] ev(int g, int unsigned bits);
    logic [NG*DW-1:0] e = '0;
    e[g*DW +: DW] = DW'(bits);
    return e;
  endfunction

  task automatic cyc(logic [NG*DW-1:0] e, bit w, int a, int unsigned d);
    @(negedge clk);
    evt = e; wr_en = w; addr = 4'(a); wdata = DW'(d);
    @(posedge clk); #1;
    evt = '0; wr_en = 0;
  endtask

  task automatic pulse(int g, int unsigned bits); cyc(ev(g, bits), 0, 0, 0); endtask
  task automatic wr(int a, int unsigned d); cyc('0, 1, a, d); endtask

  task automatic rd(string tag, int a, int unsigned exp);
    @(negedge clk); addr = 4'(a); #1;
    check(tag, rdata, exp);
    check({tag, " model"}, rdata, ref_read(a));
  endtask

  initial begin
    #(8 * 100000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 nfault reset", nfault, 1);
    check("R11 summary reset", summary, 0);
    rst_n = 1;
    live_cmp = 1;
    for (int a = 0; a < 16; a++) rd("R11 reset read", a, 0);

    pulse(0, 1);
    rd("R1 prot flag", 0, 1);
    check("R4 prot summary", summary, 10'h001);
    check("R8 pin low", nfault, 0);
    pulse(0, 16'hFFFC);
    rd("R1 bits above width ignored", 0, 1);
    pulse(0, 2);
    wr(0, 1);
    rd("R2 w1c clears one bit", 0, 2);
    wr(0, 2);
    rd("R2 cleared", 0, 0);
    check("R8 pin high after clear", nfault, 1);

    pulse(5, 4);
    cyc(ev(5, 4), 1, 5, 4);
    rd("R3 event beats clear", 5, 4);
    wr(12, 8'h20);
    rd("R9 flag kept on mask", 5, 4);
    check("R4 comp masked", summary, 0);
    wr(5, 4); wr(12, 0);

    pulse(1, 1);
    wr(12, 8'h02);
    check("R5 ut masked", summary, 0);
    pulse(2, 8);
    check("R5 ot unmasked", summary, 10'h002);
    wr(12, 8'h06);
    check("R5 both masked", summary, 0);
    rd("R1 masked ut flag", 1, 1);
    pulse(4, 32);
    wr(12, 8'h16);
    pulse(3, 1);
    check("R5 uv live ov masked", summary, 10'h004);
    wr(12, 8'hFF);
    check("R8 all mask1", nfault, 1);
    wr(12, 0);
    wr(1, 16'hFFFF); wr(2, 16'hFFFF); wr(3, 16'hFFFF); wr(4, 16'hFFFF);

    wr(13, 7'h01);
    pulse(8, 2);
    check("R6 crc masked", summary, 0);
    pulse(8, 16);
    check("R6 data live", summary, 10'h040);
    wr(13, 7'h02);
    check("R6 crc live data masked", summary, 10'h040);
    wr(8, 2);
    check("R6 only data masked", summary, 0);
    wr(8, 16'hFFFF);

    wr(13, 7'h0C);
    pulse(9, 3);
    check("R7 comm and tone masked", summary, 0);
    pulse(9, 8);
    check("R7 hb fast live", summary, 10'h080);
    wr(13, 7'h1C);
    check("R7 all masked", summary, 0);
    rd("R7 flags kept", 9, 11);
    wr(9, 16'hFFFF);

    wr(13, 16'hFFFF);
    rd("R10 mask2 width", 13, 16'h007F);
    wr(12, 16'hFFFF);
    rd("R10 mask1 width", 12, 16'h00FF);
    pulse(10, 7); pulse(11, 15); pulse(6, 31); pulse(7, 15);
    check("R8 all masked pin high", nfault, 1);
    wr(13, 7'h3F);
    check("R4 comm1 live", summary, 10'h200);
    wr(14, 16'hFFFF);
    rd("R10 summary read", 14, 16'h0200);
    rd("R10 addr 15", 15, 0);
    wr(12, 0); wr(13, 0);
    rd("R9 flags survive masks", 10, 7);

    for (int i = 0; i < 600; i++) begin
      logic [NG*DW-1:0] e = '0;
      for (int g = 0; g < NG; g++)
        if ($urandom % 6 == 0) e[g*DW +: DW] = DW'($urandom);
      cyc(e, ($urandom % 3) == 0, $urandom % 16, $urandom);
      if (i % 8 == 0) begin
        int a = $urandom % 16;
        @(negedge clk); addr = 4'(a); #1;
        check("R10 random read", rdata, ref_read(a));
      end
    end

    live_cmp = 0;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule